// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a single host port and one asynchronous DRAM with a 4-bit data path. The host port uses valid/ready. The DRAM has multiplexed row and column addresses. The host issues word reads and writes on a flat address. The upper field of that address selects a DRAM row and the lower field selects a column. The controller opens a row by dropping the row strobe. It then serves every following request to the same row as a short column-strobe cycle, with the row still open. Only when the row changes, the page grows too old, or a refresh is requested does it raise the row strobe, wait out the precharge and move on.

All DRAM timing is expressed in controller clock cycles through parameters. The row-to-column delay, column-strobe width, column precharge, row precharge and the longest time a row may stay open are each set from the DRAM's nanosecond limits and the clock period. Writes are always early writes: the write strobe falls before the column strobe. Reads sample the data bus on the last cycle the column strobe is low, which falls after every access-time limit. An external refresh sequencer asks for the bus with a request line. The controller closes any open page, holds both strobes inactive and grants the bus until the request drops.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and straight after reset, both strobes, the write strobe and the output-enable strobe are high, the data bus is not driven, `req_ready` is high, and `ref_grant` and `rsp_valid` are low.
- R2: The request address is split into a row (upper ROW_W bits) and a column (lower COL_W bits). A write stores `req_wdata` at that row and column, and a later read of the same address returns it on `rsp_rdata`.
- R3: While a page is open, each further request to the same row is served without a new falling edge on the row strobe. A run of requests within one row, started from a closed page, opens the row exactly once, provided the run ends before the open-time limit.
- R4: A request to a row other than the open one makes the row strobe rise and stay high for at least T_RP cycles before the new row is opened. Every change of row costs exactly one new row opening.
- R5: The first column strobe of a row falls exactly T_RCD+1 cycles after the row strobe falls. The row address is on the pins for the first T_RCD of those cycles. The column strobe stays low for exactly T_CAS cycles, and the address pins hold steady while it is low. Between page cycles the column strobe stays high for at least T_CP+1 cycles.
- R6: The row strobe is never low for more than T_RAS_MAX consecutive cycles. An open page with no traffic closes by itself before that limit.
- R7: On a write, the write strobe is already low in the cycle before the column strobe falls, and the data bus is driven while the column strobe falls. On a read, the write strobe is high, the bus is not driven and the output-enable strobe is low when the column strobe falls.
- R8: Read data is captured on the last cycle the column strobe is low. `rsp_valid` pulses for one cycle, in the cycle the column strobe rises, with that data.
- R9: While `ref_req` is high, `req_ready` is low. An open page is closed and `ref_grant` rises only with both strobes high. After `ref_req` falls, the row strobe stays high for at least T_RP cycles, and the next access reopens its row.
- R10: The column strobe is never low while the row strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DW | Read data |
| ref_req | input | 1 | Refresh sequencer asks for the DRAM |
| ref_grant | output | 1 | Strobes idle, DRAM handed to the sequencer |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | DW | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_o` |
| dram_dq_i | input | DW | Data returned by the DRAM |

## Verification
The hardest case to reach is the page expiring while it is busy serving hits. The host must keep one row busy long enough for the age guard to refuse a hit and force a reopen. The bench builds the controller with a short open-time limit and a small array. It streams two dozen reads to one row and checks that the row strobe reopened while no low period exceeded the limit. It also leaves a page idle past the limit and looks for the self-close at the pins. A bus-modelling DRAM stores by latched row and column. Full write and read sweeps then confirm that the multiplexed address reached the right cell, in row-major and column-major order.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // page closed, precharge done
        ST_ROW,    // row strobe low, row address on pins
        ST_COL,    // column address set up, strobe still high
        ST_CASLO,  // column strobe low
        ST_CASHI,  // column precharge inside the page
        ST_PAGE,   // page open, waiting for a request
        ST_PRE,    // row precharge
        ST_REF     // bus handed to refresh sequencer
    } fpm_state_e;
endpackage

// File: rtl/fpm_cnt.sv
module fpm_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/fpm_addr_split.sv
module fpm_addr_split #(
    parameter int ROW_W = 11,
    parameter int COL_W = 11
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic [ROW_W-1:0]       open_row,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col,
    output logic                   hit
);
    assign row = addr[ROW_W+COL_W-1:COL_W];
    assign col = addr[COL_W-1:0];
    assign hit = (row == open_row);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int COL_W     = 11,
    parameter int DW        = 4,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 3,
    parameter int T_CP      = 1,
    parameter int T_RP      = 3,
    parameter int T_RAS_MAX = 10000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DW-1:0]          req_wdata,
    output logic                   rsp_valid,
    output logic [DW-1:0]          rsp_rdata,
    input  logic                   ref_req,
    output logic                   ref_grant,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DW-1:0]          dram_dq_o,
    output logic                   dram_dq_oe,
    input  logic [DW-1:0]          dram_dq_i
);
    localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int PH_MAX = (T_RCD > T_CAS) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                            : ((T_CAS > T_RP) ? T_CAS : T_RP);
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int AGE_W  = $clog2(T_RAS_MAX + 1);
    // RAS-low cycles one more page access needs: COL + CAS low + CAS high + decision
    localparam int GUARD  = T_CAS + T_CP + 2;
    localparam int RP_W   = $clog2(T_RP + 1);

    typedef struct packed {
        fpm_state_e       st;
        logic             pend;
        logic             we;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [DW-1:0]    wdata;
        logic [ROW_W-1:0] open_row;
        logic             ras_n;
        logic             cas_n;
        logic             we_n;
        logic             oe_n;
        logic             dq_oe;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    dq_o;
        logic             rsp_v;
        logic [DW-1:0]    rdata;
        logic             grant;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic [ROW_W-1:0] in_row;
    logic [COL_W-1:0] in_col;
    logic             in_hit;
    logic             ph_load;
    logic [PH_W-1:0]  ph_val;
    logic [PH_W-1:0]  ph_cnt;
    logic             ph_zero;
    logic             age_load;
    logic [AGE_W-1:0] age_cnt;
    logic             age_ok;
    logic             accept;

    fpm_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr     (req_addr),
        .open_row (ctl_q.open_row),
        .row      (in_row),
        .col      (in_col),
        .hit      (in_hit)
    );

    fpm_cnt #(.W(PH_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .dec      (1'b1),
        .cnt      (ph_cnt)
    );

    fpm_cnt #(.W(AGE_W)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (age_load),
        .load_val (AGE_W'(T_RAS_MAX - 1)),
        .dec      (!ctl_q.ras_n),
        .cnt      (age_cnt)
    );

    assign ph_zero   = (ph_cnt == '0);
    assign age_ok    = (age_cnt >= AGE_W'(GUARD));
    assign req_ready = !ref_req &&
                       ((ctl_q.st == ST_IDLE) || (ctl_q.st == ST_PAGE && age_ok));
    assign accept    = req_valid && req_ready;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        if (accept) begin
            ctl_d.we    = req_we;
            ctl_d.row   = in_row;
            ctl_d.col   = in_col;
            ctl_d.wdata = req_wdata;
        end
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ref_req)     ctl_d.st = ST_REF;
                else if (accept) ctl_d.st = ST_ROW;
            end
            ST_ROW:   if (ph_zero) ctl_d.st = ST_COL;
            ST_COL:   ctl_d.st = ST_CASLO;
            ST_CASLO: begin
                if (ph_zero) begin
                    ctl_d.st = ST_CASHI;
                    if (!ctl_q.we) begin
                        ctl_d.rsp_v = 1'b1;
                        ctl_d.rdata = dram_dq_i;
                    end
                end
            end
            ST_CASHI: if (ph_zero) ctl_d.st = ST_PAGE;
            ST_PAGE: begin
                if (ref_req || !age_ok) begin
                    ctl_d.st = ST_PRE;
                end else if (accept) begin
                    if (in_hit) begin
                        ctl_d.st = ST_COL;
                    end else begin
                        ctl_d.st   = ST_PRE;
                        ctl_d.pend = 1'b1;
                    end
                end
            end
            ST_PRE: begin
                if (ph_zero) begin
                    if (ctl_q.pend) begin
                        ctl_d.st   = ST_ROW;
                        ctl_d.pend = 1'b0;
                    end else if (ref_req) begin
                        ctl_d.st = ST_REF;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end
            end
            ST_REF:   if (!ref_req) ctl_d.st = ST_PRE;
            default:  ctl_d.st = ST_IDLE;
        endcase

        if (ctl_d.st == ST_ROW) ctl_d.open_row = ctl_d.row;

        // pins follow the next state so they leave a flop
        ctl_d.ras_n = !(ctl_d.st inside {ST_ROW, ST_COL, ST_CASLO, ST_CASHI, ST_PAGE});
        ctl_d.cas_n = (ctl_d.st != ST_CASLO);
        ctl_d.we_n  = !(ctl_d.we && (ctl_d.st inside {ST_COL, ST_CASLO}));
        ctl_d.dq_oe = ctl_d.we && (ctl_d.st inside {ST_COL, ST_CASLO});
        ctl_d.oe_n  = !(!ctl_d.we && (ctl_d.st inside {ST_COL, ST_CASLO}));
        ctl_d.dq_o  = ctl_d.wdata;
        ctl_d.grant = (ctl_d.st == ST_REF);
        if (ctl_d.st == ST_ROW || (ctl_d.st == ST_PRE && ctl_d.pend))
            ctl_d.addr = AW'(ctl_d.row);
        else if (ctl_d.st inside {ST_COL, ST_CASLO, ST_CASHI})
            ctl_d.addr = AW'(ctl_d.col);
    end

    always_comb begin
        ph_load = (ctl_d.st != ctl_q.st);
        unique case (ctl_d.st)
            ST_ROW:   ph_val = PH_W'(T_RCD - 1);
            ST_CASLO: ph_val = PH_W'(T_CAS - 1);
            ST_CASHI: ph_val = PH_W'(T_CP - 1);
            ST_PRE:   ph_val = PH_W'(T_RP - 1);
            default:  ph_val = '0;
        endcase
        age_load = (ctl_d.st == ST_ROW) && (ctl_q.st != ST_ROW);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
            ctl_q.ras_n <= 1'b1;
            ctl_q.cas_n <= 1'b1;
            ctl_q.we_n  <= 1'b1;
            ctl_q.oe_n  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid  = ctl_q.rsp_v;
    assign rsp_rdata  = ctl_q.rdata;
    assign ref_grant  = ctl_q.grant;
    assign dram_addr  = ctl_q.addr;
    assign dram_ras_n = ctl_q.ras_n;
    assign dram_cas_n = ctl_q.cas_n;
    assign dram_we_n  = ctl_q.we_n;
    assign dram_oe_n  = ctl_q.oe_n;
    assign dram_dq_o  = ctl_q.dq_o;
    assign dram_dq_oe = ctl_q.dq_oe;

    // ---------------- pin-level checks ----------------
    logic [AGE_W:0]  ras_lo_cnt_q;
    logic [RP_W-1:0] ras_hi_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_lo_cnt_q <= '0;
            ras_hi_cnt_q <= RP_W'(T_RP);
        end else begin
            ras_lo_cnt_q <= dram_ras_n ? '0 : ras_lo_cnt_q + 1'b1;
            if (!dram_ras_n)
                ras_hi_cnt_q <= '0;
            else if (ras_hi_cnt_q != RP_W'(T_RP))
                ras_hi_cnt_q <= ras_hi_cnt_q + 1'b1;
        end
    end

    // R6
    ras_low_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_lo_cnt_q <= (AGE_W+1)'(T_RAS_MAX));

    // R4
    row_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> ras_hi_cnt_q >= RP_W'(T_RP));

    // R10
    cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R7
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> (!$past(dram_we_n) && dram_dq_oe));

    // R5
    col_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> $stable(dram_addr));

    // R8
    rsp_at_cas_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(dram_cas_n));

    // R9
    grant_idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_grant |-> (dram_ras_n && dram_cas_n));
endmodule

// File: tb/fpm_dram_ctrl_tb.sv
module fpm_dram_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 3;
    localparam int COL_W = 3;
    localparam int DW    = 4;
    localparam int T_RCD = 2;
    localparam int T_CAS = 3;
    localparam int T_CP  = 1;
    localparam int T_RP  = 3;
    localparam int T_RAS_MAX = 100;
    localparam int AW    = 3;
    localparam int NW    = 1 << (ROW_W + COL_W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [ROW_W+COL_W-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, ref_grant;
    logic [DW-1:0] rsp_rdata;
    logic ref_req = 1'b0;
    logic [AW-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [DW-1:0] dram_dq_o, dram_dq_i;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpm_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RCD(T_RCD),
        .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req),
        .ref_grant(ref_grant), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i));

    // ---- DRAM bus model ----
    logic [DW-1:0] mem [NW];
    logic [ROW_W-1:0] row_l = '0;
    logic [COL_W-1:0] col_l = '0;
    initial for (int i = 0; i < NW; i++) mem[i] = '0;
    always @(negedge dram_ras_n) row_l = dram_addr[ROW_W-1:0];
    always @(negedge dram_cas_n) begin
        col_l = dram_addr[COL_W-1:0];
        if (!dram_we_n) mem[{row_l, col_l}] = dram_dq_o;
    end
    assign dram_dq_i = (!dram_cas_n && !dram_oe_n) ? mem[{row_l, col_l}] : '0;

    // ---- pin monitor ----
    int opens = 0, ras_lo = 0, ras_hi = 1000, ras_lo_max = 0;
    int cas_lo = 0, cas_hi = 1000;
    int v_rp = 0, v_rcd = 0, v_cp = 0, v_casw = 0, v_wr = 0, v_cas = 0;
    bit first_cas = 1'b0;
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
    always @(negedge clk) if (rst_n) begin
        if (!dram_ras_n) begin
            if (p_ras) begin
                opens++;
                if (ras_hi < T_RP) v_rp++;
                ras_lo = 0;
                first_cas = 1'b1;
            end
            ras_lo++;
            if (ras_lo > ras_lo_max) ras_lo_max = ras_lo;
            ras_hi = 0;
        end else begin
            ras_hi++;
        end
        if (!dram_cas_n && p_cas) begin
            if (dram_ras_n) v_cas++;
            if (first_cas) begin
                if (ras_lo != T_RCD + 2) v_rcd++;
                first_cas = 1'b0;
            end else if (cas_hi < T_CP + 1) v_cp++;
            if (!dram_we_n && (p_we || !dram_dq_oe)) v_wr++;
            if (dram_we_n && (dram_oe_n || dram_dq_oe)) v_wr++;
            cas_lo = 0;
        end
        if (!dram_cas_n) begin
            cas_lo++;
            cas_hi = 0;
        end else begin
            if (!p_cas && cas_lo != T_CAS) v_casw++;
            cas_hi++;
        end
        p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 7 + 5) & 15);
    endfunction

    task automatic issue(input bit we, input int a, input logic [DW-1:0] wd);
        req_valid = 1'b1; req_we = we;
        req_addr = (ROW_W+COL_W)'(a); req_wdata = wd;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input int a, output logic [DW-1:0] d);
        int t = 0;
        issue(1'b0, a, '0);
        while (!rsp_valid && t < 50) begin @(negedge clk); t++; end
        d = rsp_valid ? rsp_rdata : 'x;
        @(negedge clk);
    endtask

    task automatic do_refresh();
        int t = 0;
        ref_req = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b0, "R9 ready low during refresh", int'(req_ready), 0);
        while (!ref_grant && t < 50) begin @(negedge clk); t++; end
        check(ref_grant && dram_ras_n && dram_cas_n, "R9 grant with idle strobes",
              int'({ref_grant, dram_ras_n, dram_cas_n}), 7);
        repeat (3) @(negedge clk);
        ref_req = 1'b0;
        repeat (T_RP + 2) @(negedge clk);
    endtask

    initial begin
        logic [DW-1:0] d;
        int o0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe,
              "R1 strobes idle", int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe}), 30);
        check(req_ready && !ref_grant && !rsp_valid, "R1 handshake idle",
              int'({req_ready, ref_grant, rsp_valid}), 4);

        // R2/R3: row-major write sweep, one open per row
        o0 = opens;
        for (int a = 0; a < NW; a++) issue(1'b1, a, pat(a));
        check(opens - o0 == (1 << ROW_W), "R3 one open per row", opens - o0, 1 << ROW_W);

        // R2/R4: column-major read sweep, every access a row miss
        do_refresh();
        o0 = opens;
        for (int c = 0; c < (1 << COL_W); c++)
            for (int r = 0; r < (1 << ROW_W); r++) begin
                do_read(r * (1 << COL_W) + c, d);
                check(d === pat(r * (1 << COL_W) + c), "R2 read data", int'(d),
                      int'(pat(r * (1 << COL_W) + c)));
            end
        check(opens - o0 == NW, "R4 open per row change", opens - o0, NW);

        // R4 alternating rows
        do_refresh();
        o0 = opens;
        for (int k = 0; k < 4; k++) do_read(((k % 2) + 1) * 8 + k, d);
        check(opens - o0 == 4, "R4 alternating rows", opens - o0, 4);

        // R3 same row from closed page
        do_refresh();
        o0 = opens;
        for (int k = 0; k < 4; k++) do_read(5 * 8 + k, d);
        check(opens - o0 == 1, "R3 same row hits", opens - o0, 1);

        // R9 refresh closes page; next access reopens
        do_refresh();
        o0 = opens;
        do_read(5 * 8 + 2, d);
        check(opens - o0 == 1, "R9 reopen after refresh", opens - o0, 1);
        check(d === pat(42), "R8 data after refresh", int'(d), int'(pat(42)));

        // R6 long run on one row must reopen
        do_refresh();
        o0 = opens;
        for (int k = 0; k < 24; k++) do_read(3 * 8 + (k % 8), d);
        check(opens - o0 >= 2, "R6 page aged out", opens - o0, 2);
        check(ras_lo_max <= T_RAS_MAX, "R6 ras low max", ras_lo_max, T_RAS_MAX);

        // R6 idle page closes by itself
        do_read(7 * 8, d);
        repeat (T_RAS_MAX + 10) @(negedge clk);
        check(dram_ras_n == 1'b1, "R6 idle page closed", int'(dram_ras_n), 1);

        // R7 write after aging: overwrite and read back
        issue(1'b1, 9, 4'hA);
        do_read(9, d);
        check(d === 4'hA, "R7 early write stored", int'(d), 10);

        // monitor results
        check(v_rp == 0, "R4 precharge violations", v_rp, 0);
        check(v_rcd == 0, "R5 ras-to-cas violations", v_rcd, 0);
        check(v_cp == 0, "R5 cas precharge violations", v_cp, 0);
        check(v_casw == 0, "R5 cas width violations", v_casw, 0);
        check(v_wr == 0, "R7 write/read strobe violations", v_wr, 0);
        check(v_cas == 0, "R10 cas without ras", v_cas, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule